// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block buffers complete frames from a CEC bit-level receiver until the host reads them. Each incoming frame arrives on one cycle. It carries a header byte, a command byte, up to fourteen operand bytes, an operand count and an error flag. The block stores up to `DEPTH` whole frames. Storage and removal work on whole frames, never on single bytes.

The host sees only the oldest queued frame, through a small register window. One packed status word gives:
- the operand count of the oldest frame,
- how many frames are queued,
- the error flag of the oldest frame.

Separate registers return the header byte and the command byte. The operands sit at word-spaced addresses. The host removes the oldest frame, or empties the whole queue, by writing a control register whose bits clear themselves. An accepted frame sets a not-empty event bit. A frame that finds the queue full sets a sticky overflow bit. Both bits are write-one-to-clear and reach `irq` through an enable register.

Top module: `cec_rx_frame_fifo`

## Requirements
- R1: Reading address 0x00 returns `{err, queued[2:0], opcount[3:0]}`: the oldest frame's error flag in bit 7, the number of queued frames in bits 6:4 and the oldest frame's operand count in bits 3:0. The register reads 0x00 when the queue is empty.
- R2: Address 0x04 returns the oldest frame's header byte and address 0x08 returns its command byte. Both read 0x00 when the queue is empty.
- R3: Operand i of the oldest frame reads at address 0x20 + 4*i, for i from 0 to 13. An operand address at or beyond the oldest frame's operand count reads 0x00.
- R4: Writing 0x01 to the control register at 0x0C marks a pop. The control register reads 0x01 for exactly one cycle after the write and then 0x00. At that second edge the oldest frame is removed.
- R5: Writing 0x03 to the control register marks a flush. The register reads 0x03 for one cycle, and at the next edge every queued frame is discarded. A frame arriving on that same edge is kept, so the queue then holds exactly that frame.
- R6: A frame with its error flag set occupies a slot like any other frame. It stays at the head of the queue until it is popped.
- R7: Each accepted frame sets bit 1 of the interrupt status register at 0x10. Writing 1 to that bit clears it. When a set and a clear fall on the same edge, the set wins.
- R8: `irq` is high exactly when some status bit at 0x10 is set together with the same bit of the enable register at 0x14. The enable register is read/write.
- R9: A frame that arrives while `DEPTH` frames are queued, with no flush pending, is dropped. The drop sets sticky bit 3 at 0x10, which is cleared by writing 1 to it.
- R10: Frames leave in arrival order. A pop while the queue is empty has no effect.
- R11: An incoming operand count above 14 is stored and reported as 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A complete frame is presented this cycle |
| in_hdr | input | 8 | Header byte of the incoming frame |
| in_cmd | input | 8 | Command byte of the incoming frame |
| in_ops | input | 8*MAX_OPS | Operand bytes; operand i is at bits [8i+7:8i] |
| in_nops | input | 4 | Operand count of the incoming frame |
| in_err | input | 1 | Incoming frame was received with an error |
| reg_addr | input | AW | Register byte address (read and write) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Enabled interrupt status is pending |

## Verification
The timing of each result is as follows:
- An accepted frame appears in the readable registers, and its not-empty bit sets, at the same clock edge that samples `in_valid`.
- A control write takes effect one edge after the write edge. The control register reads busy during the cycle between those two edges.
- `irq` follows the status and enable registers with no added delay.

The bench drives inputs just after each rising edge. It updates a queue-based model at the rising edge and compares `reg_rdata` and `irq` with that model at every falling edge. Directed checks of hand-computed values also sample at the falling edge, in the cycle each result is due.

// File: rtl/cec_rx_frame_fifo.sv
module cec_rx_frame_fifo #(
  parameter int DEPTH   = 4,
  parameter int MAX_OPS = 14,
  parameter int AW      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_hdr,
  input  logic [7:0]           in_cmd,
  input  logic [8*MAX_OPS-1:0] in_ops,
  input  logic [3:0]           in_nops,
  input  logic                 in_err,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_we,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [3:0]    OPMAX  = 4'(MAX_OPS);
  localparam logic [AW-1:0] A_STAT = AW'(8'h00);
  localparam logic [AW-1:0] A_HDR  = AW'(8'h04);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h08);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h0C);
  localparam logic [AW-1:0] A_IST  = AW'(8'h10);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h14);
  localparam int            OPB    = 32;
  localparam logic [7:0]    IMASK  = 8'h0A;

  logic [7:0] hdr_q [DEPTH];
  logic [7:0] cmd_q [DEPTH];
  logic [7:0] ops_q [DEPTH][MAX_OPS];
  logic [3:0] n_q   [DEPTH];
  logic       err_q [DEPTH];

  logic [CW-1:0] wptr, rptr, cnt;
  logic [1:0]    ctrl_q;
  logic [7:0]    ist_q, ien_q;
  logic          flush, pop, full, accept, drop, nonempty;
  logic [PW-1:0] rs, ws;
  logic [3:0]    nclamp;
  logic [7:0]    ist_set, ist_clr;

  assign cnt      = wptr - rptr;
  assign nonempty = cnt != '0;
  assign full     = cnt == FULL;
  assign flush    = ctrl_q[1];
  assign pop      = ctrl_q[0] & ~flush & nonempty;
  assign accept   = in_valid & (~full | flush);
  assign drop     = in_valid & ~accept;
  assign rs       = rptr[PW-1:0];
  assign ws       = wptr[PW-1:0];
  assign nclamp   = (in_nops > OPMAX) ? OPMAX : in_nops;
  assign ist_set  = {4'b0, drop, 1'b0, accept, 1'b0};
  assign ist_clr  = (reg_we && reg_addr == A_IST) ? reg_wdata : 8'h00;
  assign irq      = |(ist_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      ctrl_q <= '0;
      ist_q  <= '0;
      ien_q  <= '0;
    end else begin
      rptr   <= flush ? wptr : rptr + CW'(pop);
      wptr   <= wptr + CW'(accept);
      ctrl_q <= (reg_we && reg_addr == A_CTRL) ? reg_wdata[1:0] : 2'b00;
      ist_q  <= ((ist_q & ~ist_clr) | ist_set) & IMASK;
      if (reg_we && reg_addr == A_IEN) ien_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hdr_q[ws] <= in_hdr;
      cmd_q[ws] <= in_cmd;
      n_q[ws]   <= nclamp;
      err_q[ws] <= in_err;
      for (int i = 0; i < MAX_OPS; i++) ops_q[ws][i] <= in_ops[8*i +: 8];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_STAT: if (nonempty) reg_rdata = {err_q[rs], 3'(cnt), n_q[rs]};
      A_HDR:  if (nonempty) reg_rdata = hdr_q[rs];
      A_CMD:  if (nonempty) reg_rdata = cmd_q[rs];
      A_CTRL: reg_rdata = {6'b0, ctrl_q};
      A_IST:  reg_rdata = ist_q;
      A_IEN:  reg_rdata = ien_q;
      default: begin
        for (int i = 0; i < MAX_OPS; i++)
          if (reg_addr == AW'(OPB + 4*i) && nonempty && 4'(i) < n_q[rs])
            reg_rdata = ops_q[rs][i];
      end
    endcase
  end
endmodule

module cec_rx_frame_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   reg_we,
  input logic [AW-1:0]          reg_addr,
  input logic [1:0]             ctrl_q,
  input logic [7:0]             ist_q,
  input logic [7:0]             ien_q,
  input logic [$clog2(DEPTH):0] cnt,
  input logic                   irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h0C);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h14);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  // R4
  ctrl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != 2'b00 && !(reg_we && reg_addr == A_CTRL)) |=> ctrl_q == 2'b00);
  // R4
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b01 && cnt != '0 && !in_valid) |=> $past(cnt) == cnt + 1'b1);
  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] |=> cnt <= CW'(1));
  // R9
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt == FULL && !ctrl_q[1]) |=> ist_q[3]);
  // R7
  not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cnt != FULL || ctrl_q[1])) |=> ist_q[1]);
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt != FULL && ien_q[1] && !(reg_we && reg_addr == A_IEN)) |=> irq);
endmodule

bind cec_rx_frame_fifo cec_rx_frame_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .ctrl_q(ctrl_q), .ist_q(ist_q), .ien_q(ien_q),
  .cnt(cnt), .irq(irq)
);

// File: tb/cec_rx_frame_fifo_tb.sv
module cec_rx_frame_fifo_tb;
  localparam int NOPS = 14;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [7:0] in_hdr = 0, in_cmd = 0;
  logic [8*NOPS-1:0] in_ops = 0;
  logic [3:0] in_nops = 0;
  logic in_err = 0;
  logic [7:0] reg_addr = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq;

  int tests = 0, fails = 0, cyc = 0;

  cec_rx_frame_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
    .in_cmd(in_cmd), .in_ops(in_ops), .in_nops(in_nops), .in_err(in_err),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // reference model
  logic [7:0]        q_hdr[$], q_cmd[$];
  logic [3:0]        q_n[$];
  logic              q_err[$];
  logic [8*NOPS-1:0] q_ops[$];
  logic [1:0] m_ctrl = 0;
  logic [7:0] m_ist = 0, m_ien = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_hdr.delete(); q_cmd.delete(); q_n.delete(); q_err.delete(); q_ops.delete();
      m_ctrl = 0; m_ist = 0; m_ien = 0;
    end else begin
      automatic bit fl = m_ctrl[1];
      automatic bit pp = m_ctrl[0] && !fl;
      automatic bit acc = in_valid && (q_hdr.size() < 4 || fl);
      if (fl) begin
        q_hdr.delete(); q_cmd.delete(); q_n.delete(); q_err.delete(); q_ops.delete();
      end else if (pp && q_hdr.size() > 0) begin
        void'(q_hdr.pop_front()); void'(q_cmd.pop_front()); void'(q_n.pop_front());
        void'(q_err.pop_front()); void'(q_ops.pop_front());
      end
      if (acc) begin
        q_hdr.push_back(in_hdr); q_cmd.push_back(in_cmd);
        q_n.push_back(in_nops > 14 ? 4'd14 : in_nops);
        q_err.push_back(in_err); q_ops.push_back(in_ops);
      end
      if (reg_we && reg_addr == 8'h10) m_ist = m_ist & ~reg_wdata;
      if (acc) m_ist[1] = 1;
      if (in_valid && !acc) m_ist[3] = 1;
      m_ist = m_ist & 8'h0A;
      m_ctrl = (reg_we && reg_addr == 8'h0C) ? reg_wdata[1:0] : 2'b00;
      if (reg_we && reg_addr == 8'h14) m_ien = reg_wdata;
    end
  end

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    automatic bit ne = q_hdr.size() > 0;
    case (a)
      8'h00: return ne ? {q_err[0], 3'(q_hdr.size()), q_n[0]} : 8'h00;
      8'h04: return ne ? q_hdr[0] : 8'h00;
      8'h08: return ne ? q_cmd[0] : 8'h00;
      8'h0C: return {6'b0, m_ctrl};
      8'h10: return m_ist;
      8'h14: return m_ien;
      default: begin
        for (int i = 0; i < NOPS; i++)
          if (a == 8'(32 + 4*i)) return (ne && i < int'(q_n[0])) ? q_ops[0][8*i +: 8] : 8'h00;
        return 8'h00;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00) return "R1";
    if (a == 8'h04 || a == 8'h08) return "R2";
    if (a == 8'h0C) return "R4";
    if (a == 8'h10) return "R7";
    if (a == 8'h14) return "R8";
    return "R3";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [7:0] e = model_rd(reg_addr);
      tests++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s addr %h: actual %h expected %h", tag_of(reg_addr), reg_addr, reg_rdata, e);
      end
      tests++;
      if (irq !== |(m_ist & m_ien)) begin
        fails++;
        $display("FAIL R8 irq: actual %b expected %b", irq, |(m_ist & m_ien));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk);
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h: actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic check_now(input logic [7:0] exp, input string tag);
    @(negedge clk);
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h: actual %h expected %h", tag, reg_addr, reg_rdata, exp);
    end
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge clk);
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic set_frame(input logic [7:0] h, input logic [7:0] c, input logic [3:0] n,
                           input logic e, input logic [7:0] seed);
    in_valid = 1; in_hdr = h; in_cmd = c; in_nops = n; in_err = e;
    for (int i = 0; i < NOPS; i++) in_ops[8*i +: 8] = seed + 8'(i);
  endtask

  task automatic push(input logic [7:0] h, input logic [7:0] c, input logic [3:0] n,
                      input logic e, input logic [7:0] seed);
    @(posedge clk); #1 set_frame(h, c, n, e, seed);
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 96; a += 4) begin
      @(posedge clk); #1 reg_addr = 8'(a);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(8'h00, 8'h00, "R1 reset");
    check(8'h04, 8'h00, "R2 reset");
    check_irq(1'b0, "R8 reset");
    wr(8'h14, 8'h0A);
    push(8'h41, 8'h82, 4'd3, 1'b0, 8'h10);
    check(8'h10, 8'h02, "R7 set");
    check_irq(1'b1, "R8 enabled");
    push(8'h4F, 8'h00, 4'd0, 1'b1, 8'h30);
    check(8'h00, 8'h23, "R1 status");
    check(8'h04, 8'h41, "R2 header");
    check(8'h08, 8'h82, "R2 command");
    check(8'h28, 8'h12, "R3 last operand");
    check(8'h2C, 8'h00, "R3 beyond count");
    sweep();
    wr(8'h10, 8'h02);
    check(8'h10, 8'h00, "R7 clear");
    check_irq(1'b0, "R8 cleared");
    wr(8'h0C, 8'h01);
    check_now(8'h01, "R4 busy");
    check_now(8'h00, "R4 selfclear");
    check(8'h00, 8'h90, "R6 error frame held");
    check(8'h04, 8'h4F, "R6 header");
    push(8'h50, 8'h11, 4'd14, 1'b0, 8'h20);
    push(8'h51, 8'h12, 4'd15, 1'b0, 8'h40);
    push(8'h52, 8'h13, 4'd2, 1'b0, 8'h60);
    push(8'h53, 8'h14, 4'd1, 1'b0, 8'h70);
    check(8'h10, 8'h0A, "R9 overflow sticky");
    check(8'h00, 8'hC0, "R9 full count");
    wr(8'h0C, 8'h01);
    check(8'h00, 8'h3E, "R10 order");
    check(8'h04, 8'h50, "R10 header");
    check(8'h54, 8'h2D, "R3 operand 13");
    sweep();
    wr(8'h0C, 8'h01);
    check(8'h00, 8'h2E, "R11 clamp");
    check(8'h54, 8'h4D, "R11 operand 13");
    wr(8'h0C, 8'h03);
    set_frame(8'h5A, 8'h21, 4'd1, 1'b0, 8'h80);
    check_now(8'h03, "R5 busy");
    @(posedge clk); #1 in_valid = 0;
    check(8'h00, 8'h11, "R5 flush keeps new frame");
    check(8'h04, 8'h5A, "R5 header");
    check(8'h0C, 8'h00, "R5 selfclear");
    wr(8'h0C, 8'h01);
    check(8'h00, 8'h00, "R10 empty");
    wr(8'h0C, 8'h01);
    check(8'h00, 8'h00, "R10 pop on empty");
    check(8'h04, 8'h00, "R10 header empty");
    wr(8'h10, 8'h08);
    check(8'h10, 8'h02, "R9 clear overflow");
    wr(8'h10, 8'h02);
    wr(8'h14, 8'h00);
    push(8'h61, 8'h22, 4'd0, 1'b0, 8'h00);
    check_irq(1'b0, "R8 disabled");
    check(8'h10, 8'h02, "R7 set while disabled");
    sweep();
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule